// File: doc/BRIEF.md
# Standby Power Mode Controller

This block sequences a small processor between normal execution and four low-power states: a light sleep that halts only the CPU, a deep stop that also turns the oscillator off, and two timer-only states (time-base and watch) chosen by the clock source in use. Software requests a state by writing a one-hot request into a three-bit standby field. The controller holds the request bits while it is away from normal execution and clears them when it returns.

Wake-up comes from interrupts. Peripheral interrupts wake the light and timer-only states. Only external interrupts wake the deep stop. On the way back the controller counts, itself, an oscillator settling time and a flash-memory recovery time. Both counts are programmable and may be zero. When the CPU fetches from RAM, no flash recovery time is counted. The block drives three clock enables (CPU, peripherals, oscillator) and a 3-bit state code. After reset it can also hold the processor until two internal oscillators have settled.

Top module: `stbymode_ctrl`

## Requirements
- R1: After reset is released, the state code is 5 (boot wait). If `rst_cause` is 1, 2, 3 or 4, the boot wait lasts until both `wait_mcr` and `wait_scr` cycles have elapsed: RUN (code 0) is reached on clock edge max(wait_mcr, wait_scr)+1 after the first edge. For any other cause, RUN is reached on the first edge.
- R2: In RUN, a write with only request bit 0 set moves the state to SLEEP (code 1). In SLEEP the CPU clock is off and the peripheral clock stays on.
- R3: In RUN, a write with bit 2 set moves the state to STOP (code 2). In STOP, peripheral interrupts have no effect and only an external interrupt wakes the block.
- R4: In RUN, a write with bit 1 set (and bit 2 clear) moves the state to time-base mode (code 3) when `clk_mode` is 0 or 1. It moves to watch mode (code 4) when `clk_mode` is 2 or 3.
- R5: From SLEEP, time-base or watch mode, any interrupt starts a flash recovery wait of `wait_flash` cycles. During that wait the state is SLEEP, and RUN follows on edge `wait_flash`+1 after the wake edge.
- R6: An external interrupt in STOP starts both the oscillator wait and the flash wait on the same edge; the state code is then 6. The oscillator wait is selected by `clk_mode` (0 main, 1 main CR, 2 sub, 3 sub-CR). If the oscillator wait ends first, the state becomes SLEEP until the flash wait ends. Otherwise RUN follows directly on edge max+1 after the wake edge.
- R7: While `ram_exec` is 1, every wake path skips the flash recovery wait.
- R8: When several request bits are written together, stop wins over bit 1, and bit 1 wins over sleep. `stby_bits` is then one-hot with the chosen bit. Writes outside RUN are ignored.
- R9: `stby_bits` reads 0 whenever the state is RUN.
- R10: A write is refused, and the state stays RUN, if an interrupt that could wake the requested state is already pending. For stop that is an external line; for the other states it is any line.
- R11: A wait count of zero completes one edge after the wait starts.
- R12: `cpu_clk_en` is high only in RUN. `periph_clk_en` is high only in RUN and SLEEP. `osc_en` is low only in STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_cause | input | 3 | Cause of the last reset (1 power-on, 2 watchdog, 3 software, 4 external) |
| clk_mode | input | 2 | Active clock source: 0 main, 1 main CR, 2 sub, 3 sub-CR |
| ram_exec | input | 1 | Code runs from RAM; skips flash recovery |
| stbc_wr | input | 1 | Write strobe for the standby request field |
| stbc_wdata | input | 3 | Request bits: 0 sleep, 1 timer/watch, 2 stop |
| periph_irq | input | N_PIRQ | Peripheral interrupt lines |
| ext_irq | input | N_XIRQ | External interrupt lines |
| wait_main | input | CNT_W | Settling cycles, main oscillator |
| wait_mcr | input | CNT_W | Settling cycles, main CR oscillator |
| wait_sub | input | CNT_W | Settling cycles, sub oscillator |
| wait_scr | input | CNT_W | Settling cycles, sub-CR oscillator |
| wait_flash | input | CNT_W | Flash recovery cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| stby_bits | output | 3 | Held standby request bits |
| pm_state | output | 3 | State code |

## Verification
A wrong internal state shows at the ports within one edge, through the state code and the three clock enables. The bench checks these every cycle along each wake trace, so a wait that ends one edge early or late is caught at that edge. A race resolved the wrong way between the oscillator and flash counters shows up as a missing or extra SLEEP window on the stop wake trace. A lost request bit shows up on `stby_bits` on the cycle after entry.

// File: rtl/stbymode_pkg.sv
package stbymode_pkg;

   typedef enum logic [2:0] {
      PM_RUN   = 3'd0,
      PM_SLEEP = 3'd1,
      PM_STOP  = 3'd2,
      PM_TBT   = 3'd3,
      PM_WATCH = 3'd4,
      PM_BOOT  = 3'd5,
      PM_OSCW  = 3'd6
   } pm_state_e;

   localparam int REQ_W   = 3;
   localparam int REQ_SLP = 0;
   localparam int REQ_TMD = 1;
   localparam int REQ_STP = 2;

   function automatic logic cause_needs_wait(input logic [2:0] cause);
      return (cause == 3'd1) || (cause == 3'd2) || (cause == 3'd3) || (cause == 3'd4);
   endfunction

endpackage

// File: rtl/stby_wait_cnt.sv
module stby_wait_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] load,
   output logic         done
);
   logic [W-1:0] cnt_q;
   logic         busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= load;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/stby_irq_gate.sv
module stby_irq_gate #(
   parameter int NP   = 4,
   parameter int NX   = 2,
   parameter bit SYNC = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NP-1:0] periph_irq,
   input  logic [NX-1:0] ext_irq,
   output logic          per_any,
   output logic          ext_any
);
   logic per_raw, ext_raw;
   assign per_raw = |periph_irq;
   assign ext_raw = |ext_irq;

   generate
      if (SYNC) begin : g_sync
         logic per_q, ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_q <= 1'b0;
               ext_q <= 1'b0;
            end else begin
               per_q <= per_raw;
               ext_q <= ext_raw;
            end
         end
         assign per_any = per_q;
         assign ext_any = ext_q;
      end else begin : g_direct
         assign per_any = per_raw;
         assign ext_any = ext_raw;
      end
   endgenerate
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stbymode_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       rst_cause,
   input  logic [1:0]       clk_mode,
   input  logic             ram_exec,
   input  logic             wr,
   input  logic [REQ_W-1:0] wdata,
   input  logic             per_any,
   input  logic             ext_any,
   input  logic             done_a,
   input  logic             done_b,
   input  logic             done_f,
   output logic             start_a,
   output logic             start_b,
   output logic             start_f,
   output pm_state_e        state,
   output logic [REQ_W-1:0] bits
);
   pm_state_e        nxt;
   logic [REQ_W-1:0] nbits;
   logic             boot_q, nboot;
   logic             a_ok, b_ok, f_ok, pend_q;
   logic             na, nb, nf, npend;
   logic             a_fin, b_fin, f_fin, wake_any;

   assign wake_any = per_any | ext_any;
   assign a_fin    = a_ok | done_a;
   assign b_fin    = b_ok | done_b;
   assign f_fin    = f_ok | done_f;

   always_comb begin
      nxt = state; nbits = bits; nboot = boot_q;
      na = a_ok; nb = b_ok; nf = f_ok; npend = pend_q;
      start_a = 1'b0; start_b = 1'b0; start_f = 1'b0;
      unique case (state)
         PM_BOOT: begin
            if (boot_q) begin
               nboot = 1'b0;
               if (cause_needs_wait(rst_cause)) begin
                  start_a = 1'b1; start_b = 1'b1; na = 1'b0; nb = 1'b0;
               end else begin
                  nxt = PM_RUN;
               end
            end else if (a_fin && b_fin) begin
               nxt = PM_RUN; na = 1'b0; nb = 1'b0;
            end else begin
               na = a_fin; nb = b_fin;
            end
         end
         PM_RUN: begin
            if (wr) begin
               if (wdata[REQ_STP]) begin
                  if (!ext_any) begin nxt = PM_STOP; nbits = 3'b100; end
               end else if (wdata[REQ_TMD]) begin
                  if (!wake_any) begin
                     nxt   = clk_mode[1] ? PM_WATCH : PM_TBT;
                     nbits = 3'b010;
                  end
               end else if (wdata[REQ_SLP]) begin
                  if (!wake_any) begin nxt = PM_SLEEP; nbits = 3'b001; end
               end
            end
         end
         PM_SLEEP: begin
            if (pend_q) begin
               if (done_f) begin nxt = PM_RUN; npend = 1'b0; nbits = '0; end
            end else if (wake_any) begin
               if (ram_exec) begin nxt = PM_RUN; nbits = '0; end
               else begin start_f = 1'b1; npend = 1'b1; end
            end
         end
         PM_TBT, PM_WATCH: begin
            if (wake_any) begin
               if (ram_exec) begin nxt = PM_RUN; nbits = '0; end
               else begin nxt = PM_SLEEP; start_f = 1'b1; npend = 1'b1; end
            end
         end
         PM_STOP: begin
            if (ext_any) begin
               nxt = PM_OSCW; start_a = 1'b1; na = 1'b0;
               if (ram_exec) nf = 1'b1;
               else begin start_f = 1'b1; nf = 1'b0; end
            end
         end
         PM_OSCW: begin
            if (done_a) begin
               nf = 1'b0;
               if (f_fin) begin nxt = PM_RUN; nbits = '0; end
               else begin nxt = PM_SLEEP; npend = 1'b1; end
            end else begin
               nf = f_fin;
            end
         end
         default: begin nxt = PM_RUN; nbits = '0; npend = 1'b0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= PM_BOOT;
         bits   <= '0;
         boot_q <= 1'b1;
         a_ok   <= 1'b0;
         b_ok   <= 1'b0;
         f_ok   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         state  <= nxt;
         bits   <= nbits;
         boot_q <= nboot;
         a_ok   <= na;
         b_ok   <= nb;
         f_ok   <= nf;
         pend_q <= npend;
      end
   end
endmodule

// File: rtl/stbymode_ctrl.sv
module stbymode_ctrl
   import stbymode_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int N_PIRQ   = 4,
   parameter int N_XIRQ   = 2,
   parameter bit IRQ_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        rst_cause,
   input  logic [1:0]        clk_mode,
   input  logic              ram_exec,
   input  logic              stbc_wr,
   input  logic [2:0]        stbc_wdata,
   input  logic [N_PIRQ-1:0] periph_irq,
   input  logic [N_XIRQ-1:0] ext_irq,
   input  logic [CNT_W-1:0]  wait_main,
   input  logic [CNT_W-1:0]  wait_mcr,
   input  logic [CNT_W-1:0]  wait_sub,
   input  logic [CNT_W-1:0]  wait_scr,
   input  logic [CNT_W-1:0]  wait_flash,
   output logic              cpu_clk_en,
   output logic              periph_clk_en,
   output logic              osc_en,
   output logic [2:0]        stby_bits,
   output logic [2:0]        pm_state
);
   localparam int MAX_CNT_W = 24;

   generate
      if (CNT_W < 1 || CNT_W > MAX_CNT_W) begin : g_bad_cnt_w
         $error("stbymode_ctrl: CNT_W out of range");
      end
      if (N_PIRQ < 1 || N_XIRQ < 1) begin : g_bad_irq
         $error("stbymode_ctrl: interrupt widths must be at least 1");
      end
   endgenerate

   pm_state_e         st;
   logic              per_any, ext_any;
   logic              start_a, start_b, start_f;
   logic              done_a, done_b, done_f;
   logic [CNT_W-1:0]  osc_sel, load_a;

   stby_irq_gate #(.NP(N_PIRQ), .NX(N_XIRQ), .SYNC(IRQ_SYNC)) u_irq (
      .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .ext_irq(ext_irq),
      .per_any(per_any), .ext_any(ext_any));

   always_comb begin
      unique case (clk_mode)
         2'd0:    osc_sel = wait_main;
         2'd1:    osc_sel = wait_mcr;
         2'd2:    osc_sel = wait_sub;
         default: osc_sel = wait_scr;
      endcase
   end
   assign load_a = (st == PM_BOOT) ? wait_mcr : osc_sel;

   stby_wait_cnt #(.W(CNT_W)) u_osc_cnt (
      .clk(clk), .rst_n(rst_n), .start(start_a), .load(load_a), .done(done_a));
   stby_wait_cnt #(.W(CNT_W)) u_aux_cnt (
      .clk(clk), .rst_n(rst_n), .start(start_b), .load(wait_scr), .done(done_b));
   stby_wait_cnt #(.W(CNT_W)) u_fl_cnt (
      .clk(clk), .rst_n(rst_n), .start(start_f), .load(wait_flash), .done(done_f));

   stby_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .clk_mode(clk_mode),
      .ram_exec(ram_exec), .wr(stbc_wr), .wdata(stbc_wdata),
      .per_any(per_any), .ext_any(ext_any),
      .done_a(done_a), .done_b(done_b), .done_f(done_f),
      .start_a(start_a), .start_b(start_b), .start_f(start_f),
      .state(st), .bits(stby_bits));

   assign pm_state      = st;
   assign cpu_clk_en    = (st == PM_RUN);
   assign periph_clk_en = (st == PM_RUN) || (st == PM_SLEEP);
   assign osc_en        = (st != PM_STOP);
endmodule

// File: rtl/stbymode_ctrl_chk.sv
module stbymode_ctrl_chk #(
   parameter int NP   = 4,
   parameter int NX   = 2,
   parameter bit SYNC = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stbc_wr,
   input logic [NP-1:0] periph_irq,
   input logic [NX-1:0] ext_irq,
   input logic          cpu_clk_en,
   input logic          periph_clk_en,
   input logic          osc_en,
   input logic [2:0]    stby_bits,
   input logic [2:0]    pm_state
);
   AST_BITS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stby_bits)); // R8
   AST_BITS_CLEAR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 3'd0) |-> (stby_bits == 3'd0)); // R9
   AST_LP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state != 3'd0) |=> ((pm_state == 3'd0) || $stable(stby_bits))); // R8
   AST_STOP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 3'd2) |-> (!osc_en && !cpu_clk_en && !periph_clk_en)); // R12
   AST_CPU_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (periph_clk_en && osc_en)); // R12
   AST_SLEEP_PERIPH_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_state == 3'd1) |-> (periph_clk_en && !cpu_clk_en)); // R2

   generate
      if (!SYNC) begin : g_direct_irq
         AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((pm_state == 3'd2) && (ext_irq == '0)) |=> (pm_state == 3'd2)); // R3
         AST_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            ((pm_state == 3'd0) && stbc_wr && (ext_irq != '0)) |=> (pm_state == 3'd0)); // R10
         AST_TIMER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
            (((pm_state == 3'd3) || (pm_state == 3'd4)) && (periph_irq != '0))
            |=> ((pm_state == 3'd1) || (pm_state == 3'd0))); // R5
      end
   endgenerate
endmodule

bind stbymode_ctrl stbymode_ctrl_chk #(.NP(N_PIRQ), .NX(N_XIRQ), .SYNC(IRQ_SYNC)) u_chk (
   .clk(clk), .rst_n(rst_n), .stbc_wr(stbc_wr), .periph_irq(periph_irq),
   .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
   .osc_en(osc_en), .stby_bits(stby_bits), .pm_state(pm_state));

// File: tb/stbymode_ctrl_tb.sv
module stbymode_ctrl_tb;
   localparam int W  = 8;
   localparam int NP = 4;
   localparam int NX = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [2:0]    rst_cause = 3'd0;
   logic [1:0]    clk_mode = 2'd0;
   logic          ram_exec = 1'b0;
   logic          stbc_wr = 1'b0;
   logic [2:0]    stbc_wdata = 3'd0;
   logic [NP-1:0] periph_irq = '0;
   logic [NX-1:0] ext_irq = '0;
   logic [W-1:0]  wait_main = 8'd0, wait_mcr = 8'd0, wait_sub = 8'd0, wait_scr = 8'd0, wait_flash = 8'd0;
   logic          cpu_clk_en, periph_clk_en, osc_en;
   logic [2:0]    stby_bits, pm_state;

   stbymode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .clk_mode(clk_mode),
      .ram_exec(ram_exec), .stbc_wr(stbc_wr), .stbc_wdata(stbc_wdata),
      .periph_irq(periph_irq), .ext_irq(ext_irq), .wait_main(wait_main),
      .wait_mcr(wait_mcr), .wait_sub(wait_sub), .wait_scr(wait_scr),
      .wait_flash(wait_flash), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .osc_en(osc_en), .stby_bits(stby_bits), .pm_state(pm_state));

   int n_chk = 0, n_fail = 0;
   int cur_s = 0, cur_b = 0;
   bit done_flag = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // R12 clock enables derived from the expected state
   task automatic chk_st(input string req, input int es, input int eb);
      chk(req, "state", int'(pm_state), es);
      chk(req, "bits", int'(stby_bits), eb);
      chk({req, "/R12"}, "cpu_clk_en", int'(cpu_clk_en), (es == 0) ? 1 : 0);
      chk({req, "/R12"}, "periph_clk_en", int'(periph_clk_en), (es == 0 || es == 1) ? 1 : 0);
      chk({req, "/R12"}, "osc_en", int'(osc_en), (es == 2) ? 0 : 1);
   endtask

   function automatic int osc_for_mode(input int m);
      case (m)
         0: return int'(wait_main);
         1: return int'(wait_mcr);
         2: return int'(wait_sub);
         default: return int'(wait_scr);
      endcase
   endfunction

   function automatic int entry_state(input int bits, input int mode, input bit pe, input bit pp);
      if (bits[2]) return pe ? 0 : 2;
      if (bits[1]) return (pe || pp) ? 0 : ((mode >= 2) ? 4 : 3);
      if (bits[0]) return (pe || pp) ? 0 : 1;
      return 0;
   endfunction

   function automatic int exp_wake(input int from, input int m, input int no, input int nf, input bit ram);
      int mx;
      if (from == 2) begin
         mx = ram ? no : ((no > nf) ? no : nf);
         if (m >= mx + 1) return 0;
         if (!ram && no < nf && m >= no + 1) return 1;
         return 6;
      end
      if (ram) return 0;
      return (m >= nf + 1) ? 0 : 1;
   endfunction

   // R1 / R11 boot wait
   task automatic do_reset(input int cause, input int na, input int nb);
      step();
      rst_n = 1'b0; stbc_wr = 0; periph_irq = '0; ext_irq = '0;
      rst_cause = 3'(cause); wait_mcr = 8'(na); wait_scr = 8'(nb);
      step(); step();
      chk_st("R1 reset", 5, 0);
      rst_n = 1'b1;
      begin
         int mx = (na > nb) ? na : nb;
         bit need = (cause >= 1 && cause <= 4);
         for (int m = 0; m <= mx + 2; m++) begin
            step();
            chk_st("R1 boot", (!need || m >= mx + 1) ? 0 : 5, 0);
         end
      end
      cur_s = 0; cur_b = 0;
   endtask

   // R2 R3 R4 R8 R10 entry
   task automatic enter(input int bits, input bit pe, input bit pp);
      stbc_wr = 1; stbc_wdata = 3'(bits);
      ext_irq = pe ? 2'b10 : 2'b00; periph_irq = pp ? 4'b0100 : 4'b0000;
      step();
      stbc_wr = 0; ext_irq = '0; periph_irq = '0;
      cur_s = entry_state(bits, int'(clk_mode), pe, pp);
      cur_b = (cur_s == 0) ? 0 : (bits[2] ? 4 : (bits[1] ? 2 : 1));
      chk_st("R2/R3/R4/R8/R10 entry", cur_s, cur_b);
   endtask

   // R8 write ignored outside RUN
   task automatic ignored_write(input int bits);
      stbc_wr = 1; stbc_wdata = 3'(bits);
      step();
      stbc_wr = 0;
      chk_st("R8 ignored write", cur_s, cur_b);
   endtask

   // R5 R6 R7 R9 R11 wake trace
   task automatic wake(input bit use_ext);
      int no, nf, mx;
      no = osc_for_mode(int'(clk_mode)); nf = int'(wait_flash);
      mx = (no > nf) ? no : nf;
      if (use_ext) ext_irq = 2'b01; else periph_irq = 4'b0001;
      step();
      ext_irq = '0; periph_irq = '0;
      for (int m = 0; m <= mx + 2; m++) begin
         int es = exp_wake(cur_s, m, no, nf, ram_exec);
         chk_st("R5/R6/R7/R9/R11 wake", es, (es == 0) ? 0 : cur_b);
         if (m <= mx + 1) step();
      end
      cur_s = 0; cur_b = 0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog R1-all actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R1 causes
      do_reset(0, 4, 4);
      do_reset(6, 3, 3);
      do_reset(1, 0, 0);   // R11 zero counts
      do_reset(2, 3, 7);
      do_reset(4, 6, 2);
      // R8 priority and R4 mode selection
      clk_mode = 2'd2; wait_flash = 8'd3; wait_sub = 8'd2;
      enter(7, 0, 0); wake(1);
      clk_mode = 2'd0; enter(3, 0, 0); ignored_write(4); wake(0);
      clk_mode = 2'd3; enter(3, 0, 0); wake(0);
      clk_mode = 2'd1; enter(1, 0, 0); ignored_write(6); wake(0);
      // R10 pending interrupts
      enter(1, 0, 1);
      enter(2, 1, 0);
      enter(4, 1, 0);
      enter(4, 0, 1);               // periph not eligible for stop
      periph_irq = 4'b1000; step(); periph_irq = '0;
      chk_st("R3 periph ignored", 2, 4);
      wake(1);
      // R6 osc first, osc last, tie; R7 ram
      clk_mode = 2'd0; wait_main = 8'd1; wait_flash = 8'd5; enter(4, 0, 0); wake(1);
      wait_main = 8'd6; wait_flash = 8'd2; enter(4, 0, 0); wake(1);
      wait_main = 8'd3; wait_flash = 8'd3; enter(4, 0, 0); wake(1);
      ram_exec = 1; wait_main = 8'd1; wait_flash = 8'd5; enter(4, 0, 0); wake(1);
      enter(1, 0, 0); wake(0);
      ram_exec = 0; wait_flash = 8'd0; enter(2, 0, 0); wake(0);   // R11
      // random episodes
      for (int ep = 0; ep < 300; ep++) begin
         clk_mode = 2'($urandom % 4); ram_exec = (($urandom % 4) == 0);
         wait_main = 8'($urandom % 10); wait_mcr = 8'($urandom % 10);
         wait_sub = 8'($urandom % 10); wait_scr = 8'($urandom % 10);
         wait_flash = 8'($urandom % 10);
         enter(int'($urandom % 7) + 1, (($urandom % 8) == 0), (($urandom % 8) == 0));
         if (cur_s == 0) continue;
         ignored_write(int'($urandom % 8));
         if (cur_s == 2) begin
            periph_irq = 4'b0010; step(); periph_irq = '0;
            chk_st("R3 periph ignored", 2, cur_b);
            wake(1);
         end else begin
            wake(($urandom % 2) == 1);
         end
      end
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule